// File: doc/BRIEF.md
# Register-Mapped GPIO Bank

This block is a bank of general-purpose pins that a processor controls through a plain synchronous register port: a two-bit register select, a write strobe, a read strobe, a write word and a read word. Inside it keeps an output latch, which drives the pin output values, and a direction register, which drives one tri-state enable per pin. Pin levels come in through a two-flop synchroniser and are read back through the data register. The bank is as wide as the register word, which may be 8, 16, 32 or 64 bits.

The register set changes with build-time parameters. The output latch follows one of three models. In the data model, software writes the whole latch through the data register. In the set/clear model, a set register ORs bits into the latch and a clear register removes them. In the set-only model, the set register holds the whole output value. The direction register can be absent, or it can use output polarity (a 1 marks an output) or input polarity (a 1 marks an input). The bus view of the pins can be bit-reversed, byte-swapped, or both. A byte swap with a 64-bit word is rejected at elaboration, and so is any width other than the four listed.

Top module: `mmio_gpio`

## Requirements
- R1: After reset the output latch is zero and no pin output enable is asserted, whatever direction model is built.
- R2: A read of register select 0 (data) returns the synchronised pin levels. A read is captured on the clock edge where the read strobe is sampled, so a pin change made before edge k appears in reads captured at edge k+2 and later. Reads captured at edges k and k+1 still return the old level.
- R3: In the data model, a write to select 0 replaces the whole latch. Writes to selects 1 and 2 leave the latch unchanged.
- R4: In the set/clear model, 1s written to select 1 (set) set those latch bits, and 1s written to select 2 (clear) clear them. Bits written as 0 keep their value, and writes to select 0 leave the latch unchanged.
- R5: In the set-only model, a write to select 1 replaces the whole latch. Writes to selects 0 and 2 leave the latch unchanged.
- R6: With output polarity, a 1 in the direction register (select 3) asserts that pin's output enable.
- R7: With input polarity, a 1 in the direction register releases that pin's output enable, and the register resets to all ones.
- R8: With no direction register, writes to select 3 are ignored and it reads 0. A pin's output enable then follows its latch bit, so a pin is driven only while its latch bit is 1.
- R9: With bit reversal, logical pin n sits at bus bit WIDTH-1-n in every register.
- R10: With byte swap, bus byte i corresponds to register byte NBYTES-1-i in every register.
- R11: Select 1 reads back the latch when the set register exists, and reads 0 in the data model. Select 2 always reads 0. Select 3 reads back the direction contents. Read data changes only on a read strobe, one cycle after it, and holds at other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 data, 1 set, 2 clear, 3 direction |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | WIDTH | Write word in bus view |
| rd_data | output | WIDTH | Registered read word in bus view |
| pin_in | input | WIDTH | Asynchronous pin levels, logical order |
| pin_out | output | WIDTH | Pin output values, logical order |
| pin_oe | output | WIDTH | Pin output enables, logical order |

## Verification
The bench builds three variants side by side. The first is byte-swapped with a set/clear latch and output polarity. The second is bit-reversed with a data-model latch and input polarity. The third is 8-bit, set-only, with no direction register.

It targets these corner cases:
- Writes to registers a model does not decode. A design that decoded them would corrupt the latch, or show a direction register where none exists.
- Zero bits in set and clear words. A design that treated the write as a plain store would wipe untouched pins.
- The synchroniser latency. A design with one flop too few or too many would show the new pin level one edge early or late.
- Mapping of bits and bytes. A design that swapped or reversed on only one path would read back different words from the ones it was written.
- The reset direction value under input polarity. A design that cleared that register would come out of reset driving every pin.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        OUT_DATA    = 2'd0,
        OUT_SETCLR  = 2'd1,
        OUT_SETONLY = 2'd2
    } out_model_e;

    typedef enum logic [1:0] {
        DIR_NONE   = 2'd0,
        DIR_OUTPOL = 2'd1,
        DIR_INPOL  = 2'd2
    } dir_model_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_SET  = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_DIR  = 2'd3
    } reg_sel_e;

    localparam int SEL_W = 2;

    function automatic bit width_legal(input int w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;

    // R2: the output follows the input with exactly two edges of delay
    a_r2_two_stage: assert property (@(posedge clk) disable iff (rst)
        $past(!rst, 2) |-> sync_out == $past(async_in, 2));
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_pkg::*;
#(
    parameter int         WIDTH = 32,
    parameter out_model_e MODEL = OUT_SETCLR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_whole,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wval,
    output logic [WIDTH-1:0] latch
);
    logic [WIDTH-1:0] nxt;

    always_comb begin
        nxt = latch;
        if (wr_whole) nxt = wval;
        if (wr_set)   nxt = (MODEL == OUT_SETONLY) ? wval : (latch | wval);
        if (wr_clr)   nxt = latch & ~wval;
    end

    always_ff @(posedge clk) begin
        if (rst) latch <= '0;
        else     latch <= nxt;
    end

    // R1: latch clear after reset
    a_r1_latch_reset: assert property (@(posedge clk) rst |=> latch == '0);
    // R4: cleared bits are zero on the next cycle
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> (latch & $past(wval)) == '0);
    // R4: a set/clear write never touches bits written as 0
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_clr || (wr_set && MODEL == OUT_SETCLR)) |=>
        ((latch ^ $past(latch)) & ~$past(wval)) == '0);
    // R3, R5: a whole-word write lands exactly
    a_r5_whole_write: assert property (@(posedge clk) disable iff (rst)
        (wr_whole || (wr_set && MODEL == OUT_SETONLY)) |=> latch == $past(wval));
    // R3: no strobe, no change
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !(wr_whole || wr_set || wr_clr) |=> $stable(latch));
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
    parameter int         WIDTH     = 32,
    parameter logic       RESET_ONE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_dir,
    input  logic [WIDTH-1:0] wval,
    output logic [WIDTH-1:0] dir_q
);
    localparam logic [WIDTH-1:0] RST_VAL = RESET_ONE ? '1 : '0;

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= RST_VAL;
        else if (wr_dir) dir_q <= wval;
    end

    // R6, R7: a direction write is held as written
    a_r6_dir_write: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> dir_q == $past(wval));
    // R7: the reset value depends on polarity
    a_r7_dir_reset: assert property (@(posedge clk) rst |=> dir_q == RST_VAL);
endmodule

// File: rtl/mmio_gpio.sv
module mmio_gpio
    import gpio_pkg::*;
#(
    parameter int         WIDTH     = 32,
    parameter out_model_e OUT_MODEL = OUT_SETCLR,
    parameter dir_model_e DIR_MODEL = DIR_OUTPOL,
    parameter bit         BIT_REV   = 1'b0,
    parameter bit         BYTE_SWAP = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    localparam int NBYTES = WIDTH / 8;

    if (!width_legal(WIDTH)) begin : g_bad_width
        $error("mmio_gpio: WIDTH must be 8, 16, 32 or 64");
    end
    if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
        $error("mmio_gpio: byte swap is not allowed with a 64-bit word");
    end

    // Bus view <-> logical order; the mapping is its own inverse.
    function automatic logic [WIDTH-1:0] view(input logic [WIDTH-1:0] x);
        logic [WIDTH-1:0] t;
        logic [WIDTH-1:0] y;
        for (int i = 0; i < WIDTH; i++)
            t[i] = BIT_REV ? x[WIDTH-1-i] : x[i];
        y = t;
        if (BYTE_SWAP)
            for (int b = 0; b < NBYTES; b++)
                y[b*8 +: 8] = t[(NBYTES-1-b)*8 +: 8];
        return y;
    endfunction

    reg_sel_e         sel;
    logic [WIDTH-1:0] wval;
    logic             hit_whole, hit_set, hit_clr, hit_dir;
    logic [WIDTH-1:0] latch, dir_q, pins_sync, rd_mux;

    assign sel  = reg_sel_e'(reg_sel);
    assign wval = view(wr_data);

    assign hit_whole = wr_en && sel == SEL_DATA && OUT_MODEL == OUT_DATA;
    assign hit_set   = wr_en && sel == SEL_SET  && OUT_MODEL != OUT_DATA;
    assign hit_clr   = wr_en && sel == SEL_CLR  && OUT_MODEL == OUT_SETCLR;
    assign hit_dir   = wr_en && sel == SEL_DIR  && DIR_MODEL != DIR_NONE;

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pins_sync)
    );

    gpio_out_latch #(.WIDTH(WIDTH), .MODEL(OUT_MODEL)) u_latch (
        .clk(clk), .rst(rst), .wr_whole(hit_whole), .wr_set(hit_set),
        .wr_clr(hit_clr), .wval(wval), .latch(latch)
    );

    gpio_dir_reg #(.WIDTH(WIDTH), .RESET_ONE(DIR_MODEL == DIR_INPOL)) u_dir (
        .clk(clk), .rst(rst), .wr_dir(hit_dir), .wval(wval), .dir_q(dir_q)
    );

    assign pin_out = latch;

    if (DIR_MODEL == DIR_OUTPOL) begin : g_oe_out
        assign pin_oe = dir_q;
    end else if (DIR_MODEL == DIR_INPOL) begin : g_oe_in
        assign pin_oe = ~dir_q;
    end else begin : g_oe_none
        assign pin_oe = latch;
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_mux = view(pins_sync);
            SEL_SET:  rd_mux = (OUT_MODEL != OUT_DATA) ? view(latch) : '0;
            SEL_CLR:  rd_mux = '0;
            SEL_DIR:  rd_mux = (DIR_MODEL != DIR_NONE) ? view(dir_q) : '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // R1: no output enables after reset
    a_r1_oe_reset: assert property (@(posedge clk) rst |=> pin_oe == '0);
    // R11: read data holds without a read strobe
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    // R11: the clear register reads zero
    a_r11_clr_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_sel == 2'd2) |=> rd_data == '0);
    // R8: without a direction register, direction reads zero
    a_r8_no_dir_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_sel == 2'd3 && DIR_MODEL == DIR_NONE) |=> rd_data == '0);
endmodule

// File: tb/sim_mmio_gpio.sv
`timescale 1ns/1ps
module sim_mmio_gpio;
    import gpio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = '0;
    logic        rd_en = 1'b0;
    logic        wr0 = 1'b0, wr1 = 1'b0, wr2 = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] pin0 = '0;
    logic [15:0] pin1 = '0;
    logic [7:0]  pin2 = '0;
    logic [31:0] rd0, out0, oe0;
    logic [15:0] rd1, out1, oe1;
    logic [7:0]  rd2, out2, oe2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mmio_gpio #(.WIDTH(32), .OUT_MODEL(OUT_SETCLR), .DIR_MODEL(DIR_OUTPOL),
                .BIT_REV(1'b0), .BYTE_SWAP(1'b1)) u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr0), .rd_en(rd_en),
        .wr_data(wdata), .rd_data(rd0), .pin_in(pin0), .pin_out(out0), .pin_oe(oe0));

    mmio_gpio #(.WIDTH(16), .OUT_MODEL(OUT_DATA), .DIR_MODEL(DIR_INPOL),
                .BIT_REV(1'b1), .BYTE_SWAP(1'b0)) u1 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr1), .rd_en(rd_en),
        .wr_data(wdata[15:0]), .rd_data(rd1), .pin_in(pin1), .pin_out(out1), .pin_oe(oe1));

    mmio_gpio #(.WIDTH(8), .OUT_MODEL(OUT_SETONLY), .DIR_MODEL(DIR_NONE),
                .BIT_REV(1'b0), .BYTE_SWAP(1'b0)) u2 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr2), .rd_en(rd_en),
        .wr_data(wdata[7:0]), .rd_data(rd2), .pin_in(pin2), .pin_out(out2), .pin_oe(oe2));

    // Set/clear sequence on u0 (byte-swapped): select, bus word, expected logical latch
    localparam logic [65:0] VEC [8] = '{
        {2'd1, 32'h000000FF, 32'hFF000000},
        {2'd1, 32'h00001100, 32'hFF110000},
        {2'd2, 32'h01000000, 32'hFF110000},
        {2'd2, 32'h000000F0, 32'h0F110000},
        {2'd0, 32'hFFFFFFFF, 32'h0F110000},
        {2'd3, 32'h12345678, 32'h0F110000},
        {2'd2, 32'h00000000, 32'h0F110000},
        {2'd1, 32'h78563412, 32'h1F355678}
    };

    function automatic logic [31:0] swap32(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic logic [15:0] rev16(input logic [15:0] x);
        logic [15:0] y;
        for (int i = 0; i < 16; i++) y[i] = x[15-i];
        return y;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write(input int inst, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; wdata = d;
        wr0 = (inst == 0); wr1 = (inst == 1); wr2 = (inst == 2);
        @(posedge clk);
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0; wr2 = 1'b0;
    endtask

    task automatic read(input logic [1:0] s);
        @(negedge clk);
        reg_sel = s; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state of all three variants
        check("R1 u0 out", out0, 0);
        check("R1 u0 oe", oe0, 0);
        check("R1 u1 oe", oe1, 0);
        check("R1 u2 oe", oe2, 0);
        check("R1 u0 rd", rd0, 0);
        read(2'd3);
        check("R7 u1 dir resets to ones", rd1, 16'hFFFF);

        // R4 R10: table-driven set/clear walk on u0
        for (int i = 0; i < 8; i++) begin
            write(0, VEC[i][65:64], VEC[i][63:32]);
            check("R4 R10 u0 latch", out0, VEC[i][31:0]);
        end
        check("R6 R10 u0 oe", oe0, swap32(32'h12345678));
        read(2'd3);
        check("R11 u0 dir readback", rd0, 32'h12345678);
        read(2'd1);
        check("R11 R10 u0 set readback", rd0, swap32(32'h1F355678));
        read(2'd2);
        check("R11 u0 clr reads zero", rd0, 0);
        @(negedge clk);
        @(negedge clk);
        check("R11 rd holds", rd0, 0);
        pin0 = 32'h11223344;
        repeat (3) @(negedge clk);
        read(2'd0);
        check("R2 R10 u0 data", rd0, swap32(32'h11223344));

        // u1: data model, input polarity, bit reversed
        write(1, 2'd0, 32'h0001);
        check("R3 R9 u1 data write", out1, rev16(16'h0001));
        write(1, 2'd0, 32'h00F0);
        check("R3 R9 u1 replace", out1, 16'h0F00);
        write(1, 2'd1, 32'hFFFF);
        check("R3 u1 set ignored", out1, 16'h0F00);
        write(1, 2'd2, 32'hFFFF);
        check("R3 u1 clr ignored", out1, 16'h0F00);
        write(1, 2'd3, 32'h00FF);
        check("R7 R9 u1 oe", oe1, 16'h00FF);
        read(2'd1);
        check("R11 u1 set reads zero", rd1, 0);
        // R2: synchroniser latency, captures at k, k+1 old, k+2 new
        @(negedge clk);
        pin1 = 16'h0003; reg_sel = 2'd0; rd_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R2 R9 u1 latency", rd1, (i < 2) ? 16'h0000 : 16'hC000);
        end
        rd_en = 1'b0;

        // u2: set-only, no direction register
        write(2, 2'd1, 32'hA5);
        check("R5 u2 set whole", out2, 8'hA5);
        check("R8 u2 oe follows latch", oe2, 8'hA5);
        write(2, 2'd1, 32'h0F);
        check("R5 u2 replace", out2, 8'h0F);
        write(2, 2'd0, 32'hFF);
        check("R5 u2 data ignored", out2, 8'h0F);
        write(2, 2'd2, 32'hFF);
        check("R5 u2 clr ignored", out2, 8'h0F);
        write(2, 2'd3, 32'hFF);
        check("R8 u2 dir write ignored", oe2, 8'h0F);
        read(2'd3);
        check("R8 u2 dir reads zero", rd2, 0);
        read(2'd1);
        check("R11 u2 set readback", rd2, 8'h0F);
        pin2 = 8'h3C;
        repeat (3) @(negedge clk);
        read(2'd0);
        check("R2 u2 data", rd2, 8'h3C);

        // R1: reset again restores the clean state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 u0 out after reset", out0, 0);
        check("R1 u1 oe after reset", oe1, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule